// File: doc/BRIEF.md
# Two-Level Breakpoint Status Register

This block is the status side of a debug unit. It follows a two-step hardware breakpoint sequence, arming on a trigger-register write, moving through "waiting" and "triggered" codes as match pulses arrive from the address comparators, and clearing on either a fresh trigger write or a status read that sees a finished sequence. Beside that field it keeps sticky flags that say why the core stopped: a fault-on-fault, a hardware trigger, a halt instruction, or the external breakpoint pin.

The active-low breakpoint pin passes through a two-flop synchronizer. A configuration bit decides what a high-to-low edge on it means. With the bit clear, the edge records a pin-caused halt. With the bit set, the edge raises a debug interrupt request instead. That request stays pending until the core's per-instruction sample strobe takes it, and no further request is accepted until the handler reports completion. A write-protect bit stops the core from changing the configuration. Only the external debug port can set or clear that bit.

Top module: `brkpt_status_reg`

## Requirements
- R1: After reset, every flag, the interrupt request, both configuration bits and the breakpoint status field (bits 3:0) are 0. The status word therefore reads 32'h0000_0010.
- R2: Bits 7:4 of the status word always read the revision constant 4'b0001.
- R3: A trigger write with `trigArm`=1 sets the status field to 4'b0001 (waiting for level 1). A trigger write with `trigArm`=0 sets it to 4'b0000 (none enabled).
- R4: With `l2Enable`=0, a level-1 match in state 0001 moves the field to 0010. A level-2 match in state 0001 has no effect.
- R5: With `l2Enable`=1, a level-1 match in state 0001 moves the field to 0101. A later level-2 match moves it to 0110.
- R6: A status read returns the field to 0000 when the field is 0110, or when it is 0010 and `l2Enable`=0. In every other case a read leaves the field unchanged.
- R7: A trigger write takes priority over a status read and over match pulses in the same cycle, from any state.
- R8: The cause pulses `fofEvent`, `trgEvent` and `haltEvent` each set a sticky flag on the next clock edge: bit 8, bit 9 and bit 10 respectively.
- R9: `goCmd` clears bits 9, 10 and 11. The fault-on-fault flag (bit 8) is cleared only by reset.
- R10: With the breakpoint-disable bit (bit 12) at 0, a falling edge on `bkptPinN` sets the pin-halt flag (bit 11) on the third clock edge after the pin falls. It does not raise `dbgIrq`.
- R11: With bit 12 at 1, a falling edge on the pin raises `dbgIrq` on the third clock edge and leaves bit 11 unchanged. `dbgIrq` stays high until a cycle with `sampleStrobe`. That cycle drops it and sets the in-service bit (bit 14).
- R12: While bit 14 is set, pin edges raise no request. `svcDone` clears bit 14, after which edges are accepted again.
- R13: `coreWrite` loads bit 12 from `wrBkd` only while the write-inhibit bit (bit 13) is 0, and it never changes bit 13. `hostWrite` loads both bits from `wrBkd` and `wrIpw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| l1Match | input | 1 | Level-1 comparator match pulse |
| l2Match | input | 1 | Level-2 comparator match pulse |
| l2Enable | input | 1 | Level-2 stage enabled |
| trigWrite | input | 1 | Trigger-definition register write strobe |
| trigArm | input | 1 | Written trigger arms level 1 |
| csrRead | input | 1 | Status register read strobe |
| goCmd | input | 1 | Resume command from the debug port |
| fofEvent | input | 1 | Fault-on-fault halt cause pulse |
| trgEvent | input | 1 | Hardware-trigger halt cause pulse |
| haltEvent | input | 1 | Halt-instruction cause pulse |
| bkptPinN | input | 1 | Asynchronous active-low breakpoint pin |
| sampleStrobe | input | 1 | Per-instruction interrupt sample point |
| svcDone | input | 1 | Debug interrupt handler finished |
| coreWrite | input | 1 | Core-side configuration write |
| hostWrite | input | 1 | Debug-port configuration write |
| wrBkd | input | 1 | Write data for the breakpoint-disable bit |
| wrIpw | input | 1 | Write data for the write-inhibit bit |
| statusWord | output | 32 | Readable status word |
| dbgIrq | output | 1 | Pending debug interrupt request |

## Verification
The assertions assume that every strobe is a single-cycle pulse, sampled at a clock edge, and that `l2Enable` does not change in the same cycle as the match or read that depends on it. They also assume that `sampleStrobe` and `svcDone` never arrive together. The stimulus drives every input only just after a rising edge, holds `l2Enable` steady across the strobes it qualifies, and pulses each strobe for exactly one cycle. The pin goes high again and is held for several cycles between edges, so the synchronizer settles before the next falling edge.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

  typedef enum logic [3:0] {
    BS_IDLE  = 4'b0000,
    BS_WAIT1 = 4'b0001,
    BS_HIT1  = 4'b0010,
    BS_WAIT2 = 4'b0101,
    BS_HIT2  = 4'b0110
  } bkptState_t;

  typedef struct packed {
    logic pinFall;
    logic goClr;
  } ctrlStrobe_t;

  localparam logic [3:0] REV_ID = 4'b0001;

  localparam int POS_REV  = 4;
  localparam int POS_FOF  = 8;
  localparam int POS_TRG  = 9;
  localparam int POS_HALT = 10;
  localparam int POS_PIN  = 11;
  localparam int POS_BKD  = 12;
  localparam int POS_IPW  = 13;
  localparam int POS_SVC  = 14;

endpackage

// File: rtl/brkpt_ctrl.sv
module brkpt_ctrl
  import brkpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        l1Match,
  input  logic        l2Match,
  input  logic        l2Enable,
  input  logic        trigWrite,
  input  logic        trigArm,
  input  logic        csrRead,
  input  logic        goCmd,
  input  logic        bkptPinN,
  output bkptState_t  state,
  output ctrlStrobe_t strobes
);

  // Synchronizer stages plus one history stage for the edge compare.
  localparam int HIST = SYNC_STAGES;

  logic [HIST:0] syncQ;
  bkptState_t    stateQ, stateNxt;
  logic          readClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[HIST-1:0], bkptPinN};
  end

  always_comb begin
    readClr  = csrRead && ((stateQ == BS_HIT2) || ((stateQ == BS_HIT1) && !l2Enable));
    stateNxt = stateQ;
    if (trigWrite) begin
      stateNxt = trigArm ? BS_WAIT1 : BS_IDLE;
    end else if (readClr) begin
      stateNxt = BS_IDLE;
    end else begin
      case (stateQ)
        BS_WAIT1: if (l1Match) stateNxt = l2Enable ? BS_WAIT2 : BS_HIT1;
        BS_WAIT2: if (l2Match) stateNxt = BS_HIT2;
        default:  stateNxt = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= BS_IDLE;
    else       stateQ <= stateNxt;
  end

  assign state           = stateQ;
  assign strobes.pinFall = syncQ[HIST] & ~syncQ[HIST-1];
  assign strobes.goClr   = goCmd;

endmodule

// File: rtl/brkpt_dp.sv
module brkpt_dp
  import brkpt_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  bkptState_t          state,
  input  ctrlStrobe_t         strobes,
  input  logic                fofEvent,
  input  logic                trgEvent,
  input  logic                haltEvent,
  input  logic                sampleStrobe,
  input  logic                svcDone,
  input  logic                coreWrite,
  input  logic                hostWrite,
  input  logic                wrBkd,
  input  logic                wrIpw,
  output logic [STATUS_W-1:0] statusWord,
  output logic                dbgIrq
);

  logic fofQ, trgQ, haltQ, pinQ, bkdQ, ipwQ, pendQ, svcQ;
  logic pinHalt, pinIrq;

  assign pinHalt = strobes.pinFall & ~bkdQ;
  assign pinIrq  = strobes.pinFall & bkdQ & ~pendQ & ~svcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fofQ  <= 1'b0;
      trgQ  <= 1'b0;
      haltQ <= 1'b0;
      pinQ  <= 1'b0;
    end else begin
      fofQ  <= fofQ | fofEvent;
      trgQ  <= trgEvent  | (trgQ  & ~strobes.goClr);
      haltQ <= haltEvent | (haltQ & ~strobes.goClr);
      pinQ  <= pinHalt   | (pinQ  & ~strobes.goClr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bkdQ <= 1'b0;
      ipwQ <= 1'b0;
    end else if (hostWrite) begin
      bkdQ <= wrBkd;
      ipwQ <= wrIpw;
    end else if (coreWrite && !ipwQ) begin
      bkdQ <= wrBkd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      svcQ  <= 1'b0;
    end else begin
      pendQ <= pinIrq | (pendQ & ~sampleStrobe);
      svcQ  <= (pendQ & sampleStrobe) | (svcQ & ~svcDone);
    end
  end

  always_comb begin
    statusWord                      = '0;
    statusWord[3:0]                 = state;
    statusWord[POS_REV+3:POS_REV]   = REV_ID;
    statusWord[POS_FOF]             = fofQ;
    statusWord[POS_TRG]             = trgQ;
    statusWord[POS_HALT]            = haltQ;
    statusWord[POS_PIN]             = pinQ;
    statusWord[POS_BKD]             = bkdQ;
    statusWord[POS_IPW]             = ipwQ;
    statusWord[POS_SVC]             = svcQ;
  end

  assign dbgIrq = pendQ;

endmodule

// File: rtl/brkpt_status_reg.sv
module brkpt_status_reg
  import brkpt_pkg::*;
#(
  parameter int STATUS_W    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                l1Match,
  input  logic                l2Match,
  input  logic                l2Enable,
  input  logic                trigWrite,
  input  logic                trigArm,
  input  logic                csrRead,
  input  logic                goCmd,
  input  logic                fofEvent,
  input  logic                trgEvent,
  input  logic                haltEvent,
  input  logic                bkptPinN,
  input  logic                sampleStrobe,
  input  logic                svcDone,
  input  logic                coreWrite,
  input  logic                hostWrite,
  input  logic                wrBkd,
  input  logic                wrIpw,
  output logic [STATUS_W-1:0] statusWord,
  output logic                dbgIrq
);

  bkptState_t  state;
  ctrlStrobe_t strobes;

  brkpt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .l1Match   (l1Match),
    .l2Match   (l2Match),
    .l2Enable  (l2Enable),
    .trigWrite (trigWrite),
    .trigArm   (trigArm),
    .csrRead   (csrRead),
    .goCmd     (goCmd),
    .bkptPinN  (bkptPinN),
    .state     (state),
    .strobes   (strobes)
  );

  brkpt_dp #(.STATUS_W(STATUS_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .state        (state),
    .strobes      (strobes),
    .fofEvent     (fofEvent),
    .trgEvent     (trgEvent),
    .haltEvent    (haltEvent),
    .sampleStrobe (sampleStrobe),
    .svcDone      (svcDone),
    .coreWrite    (coreWrite),
    .hostWrite    (hostWrite),
    .wrBkd        (wrBkd),
    .wrIpw        (wrIpw),
    .statusWord   (statusWord),
    .dbgIrq       (dbgIrq)
  );

endmodule

// File: rtl/brkpt_status_reg_chk.sv
module brkpt_status_reg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        l2Match,
  input logic        trigWrite,
  input logic        trigArm,
  input logic        csrRead,
  input logic        goCmd,
  input logic        trgEvent,
  input logic        haltEvent,
  input logic        sampleStrobe,
  input logic        hostWrite,
  input logic [31:0] statusWord,
  input logic        dbgIrq
);

  assert_l2_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[3:0] == 4'h5 && l2Match && !trigWrite) |=> statusWord[3:0] == 4'h6);

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[3:0] == 4'h6 && csrRead && !trigWrite) |=> statusWord[3:0] == 4'h0);

  assert_trig_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    trigWrite |=> statusWord[3:0] == ($past(trigArm) ? 4'h1 : 4'h0));

  assert_go_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (goCmd && !trgEvent && !haltEvent) |=> statusWord[10:9] == 2'b00);

  assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dbgIrq && !sampleStrobe) |=> dbgIrq);

  assert_no_nest_R12: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[14] |-> !dbgIrq);

  assert_ipw_guard_R13: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrite |=> $stable(statusWord[13]));

endmodule

bind brkpt_status_reg brkpt_status_reg_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .l2Match      (l2Match),
  .trigWrite    (trigWrite),
  .trigArm      (trigArm),
  .csrRead      (csrRead),
  .goCmd        (goCmd),
  .trgEvent     (trgEvent),
  .haltEvent    (haltEvent),
  .sampleStrobe (sampleStrobe),
  .hostWrite    (hostWrite),
  .statusWord   (statusWord),
  .dbgIrq       (dbgIrq)
);

// File: tb/brkpt_status_reg_test.sv
module brkpt_status_reg_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic l1Match = 0, l2Match = 0, l2Enable = 0, trigWrite = 0, trigArm = 0;
  logic csrRead = 0, goCmd = 0, fofEvent = 0, trgEvent = 0, haltEvent = 0;
  logic bkptPinN = 1, sampleStrobe = 0, svcDone = 0;
  logic coreWrite = 0, hostWrite = 0, wrBkd = 0, wrIpw = 0;
  logic [31:0] statusWord;
  logic dbgIrq;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  logic [31:0] expWordQ[$];
  logic        expIrqQ[$];
  string       expTagQ[$];

  always #4 clk = ~clk;

  brkpt_status_reg uut (
    .clk(clk), .rstN(rstN), .l1Match(l1Match), .l2Match(l2Match), .l2Enable(l2Enable),
    .trigWrite(trigWrite), .trigArm(trigArm), .csrRead(csrRead), .goCmd(goCmd),
    .fofEvent(fofEvent), .trgEvent(trgEvent), .haltEvent(haltEvent), .bkptPinN(bkptPinN),
    .sampleStrobe(sampleStrobe), .svcDone(svcDone), .coreWrite(coreWrite),
    .hostWrite(hostWrite), .wrBkd(wrBkd), .wrIpw(wrIpw),
    .statusWord(statusWord), .dbgIrq(dbgIrq)
  );

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (expWordQ.size() > 0) begin
      logic [31:0] w;
      logic        q;
      string       t;
      w = expWordQ.pop_front();
      q = expIrqQ.pop_front();
      t = expTagQ.pop_front();
      checkCnt++;
      if (statusWord !== w || dbgIrq !== q) begin
        failCnt++;
        $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", t, statusWord, dbgIrq, w, q);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic expect_out(logic [31:0] w, logic q, string t);
    expWordQ.push_back(w);
    expIrqQ.push_back(q);
    expTagQ.push_back(t);
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    tick();
    s = 1'b0;
  endtask

  task automatic trig(logic arm);
    trigArm = arm;
    pulse(trigWrite);
    trigArm = 1'b0;
  endtask

  task automatic pinFallSettle();
    bkptPinN = 1'b0;
    tick(3);
  endtask

  task automatic pinRelease();
    bkptPinN = 1'b1;
    tick(4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin : driver
    tick(2);
    expect_out(32'h10, 1'b0, "R1 reset state / R2 revision");
    rstN = 1'b1;
    tick();
    expect_out(32'h10, 1'b0, "R2 revision after reset");

    trig(1'b1);
    expect_out(32'h11, 1'b0, "R3 armed trigger write");
    pulse(l2Match);
    expect_out(32'h11, 1'b0, "R4 level-2 match ignored while waiting level 1");
    pulse(l1Match);
    expect_out(32'h12, 1'b0, "R4 level-1 hit with level 2 disabled");
    l2Enable = 1'b1;
    pulse(csrRead);
    expect_out(32'h12, 1'b0, "R6 read keeps 0010 when level 2 enabled");
    l2Enable = 1'b0;
    pulse(csrRead);
    expect_out(32'h10, 1'b0, "R6 read clears 0010 when level 2 disabled");

    l2Enable = 1'b1;
    trig(1'b1);
    pulse(l1Match);
    expect_out(32'h15, 1'b0, "R5 level-1 hit moves to waiting level 2");
    pulse(csrRead);
    expect_out(32'h15, 1'b0, "R6 read keeps 0101");
    pulse(l2Match);
    expect_out(32'h16, 1'b0, "R5 level-2 hit");
    pulse(csrRead);
    expect_out(32'h10, 1'b0, "R6 read clears 0110");

    trig(1'b1);
    pulse(l1Match);
    trigArm = 1'b0; trigWrite = 1'b1; csrRead = 1'b1; l2Match = 1'b1;
    tick();
    trigWrite = 1'b0; csrRead = 1'b0; l2Match = 1'b0;
    expect_out(32'h10, 1'b0, "R7 trigger write wins over match and read");
    trig(1'b1);
    trigArm = 1'b1; trigWrite = 1'b1; l1Match = 1'b1;
    tick();
    trigWrite = 1'b0; trigArm = 1'b0; l1Match = 1'b0;
    expect_out(32'h11, 1'b0, "R7 armed write wins over level-1 match");
    trig(1'b0);
    expect_out(32'h10, 1'b0, "R3 unarmed trigger write");
    l2Enable = 1'b0;

    pulse(fofEvent);
    expect_out(32'h110, 1'b0, "R8 fault-on-fault flag");
    pulse(trgEvent);
    expect_out(32'h310, 1'b0, "R8 trigger flag");
    pulse(haltEvent);
    expect_out(32'h710, 1'b0, "R8 halt flag");
    pulse(goCmd);
    expect_out(32'h110, 1'b0, "R9 go clears halt causes, keeps fault-on-fault");

    bkptPinN = 1'b0;
    tick(2);
    expect_out(32'h110, 1'b0, "R10 pin flag not yet set after two edges");
    tick();
    expect_out(32'h910, 1'b0, "R10 pin flag set on third edge, no interrupt");
    pinRelease();
    pulse(goCmd);
    expect_out(32'h110, 1'b0, "R9 go clears pin flag");

    wrBkd = 1'b1;
    pulse(coreWrite);
    expect_out(32'h1110, 1'b0, "R13 core write sets disable bit when unprotected");
    pinFallSettle();
    expect_out(32'h1110, 1'b1, "R11 edge raises interrupt, no pin flag");
    tick(3);
    expect_out(32'h1110, 1'b1, "R11 request held until sample point");
    pulse(sampleStrobe);
    expect_out(32'h5110, 1'b0, "R11 sample takes request, in-service set");
    pinRelease();
    pinFallSettle();
    tick();
    expect_out(32'h5110, 1'b0, "R12 edge during service ignored");
    pulse(svcDone);
    expect_out(32'h1110, 1'b0, "R12 service done clears in-service");
    pinRelease();
    pinFallSettle();
    expect_out(32'h1110, 1'b1, "R12 edge accepted after service");
    pulse(sampleStrobe);
    pulse(svcDone);
    expect_out(32'h1110, 1'b0, "R11 request consumed and serviced");
    pinRelease();

    wrBkd = 1'b1; wrIpw = 1'b1;
    pulse(hostWrite);
    expect_out(32'h3110, 1'b0, "R13 host sets write inhibit");
    wrBkd = 1'b0; wrIpw = 1'b0;
    pulse(coreWrite);
    expect_out(32'h3110, 1'b0, "R13 core write blocked while inhibited");
    pulse(hostWrite);
    expect_out(32'h0110, 1'b0, "R13 host clears both bits");
    wrIpw = 1'b1;
    pulse(coreWrite);
    expect_out(32'h0110, 1'b0, "R13 core cannot set inhibit bit");
    wrIpw = 1'b0;

    tick(2);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule